// File: doc/BRIEF.md
# Core Timebase with Periodic Interrupt

A free-running timebase for a small microcontroller. A bus-rate enable (`tick_en_i`) advances one synchronous divider chain. The two lowest stages form a divide-by-four prescaler. The next eight stages form a counter that software can read at any time. When that counter wraps, an overflow flag is set, which happens once every 1024 enables.

The chain continues past the counter. Software picks one of four higher stages as the periodic interrupt source. The selected stage's rising edge sets a periodic flag, and the chosen period is 2048, 4096, 8192 or 16384 enables. Every eighth periodic event also produces a one-cycle tick that clocks an external watchdog.

Two register addresses are exposed:
- Address 0 is a control/status byte. It holds both flags, both interrupt enables, two write-one-to-clear strobes and the rate select.
- Address 1 is the counter.

A single interrupt request combines the two sources, each gated by its own enable.

Top module: `core_timebase`

## Requirements
- R1: After reset, address 0 reads 0x03, address 1 reads 0x00, and `irq_o` and `wd_tick_o` are low.
- R2: The counter read at address 1 equals floor(E/4) mod 256, where E is the number of cycles with `tick_en_i` high since reset. Writes to address 1 change nothing.
- R3: The overflow flag (address 0, bit 7) sets on the enable that wraps the counter from 0xFF to 0x00. It first sets after 1024 enables, and it stays set until it is cleared.
- R4: The rate select is bits 1:0 of address 0. Values 00, 01, 10 and 11 give periods of 2048, 4096, 8192 and 16384 enables. The periodic flag (bit 6) sets on the rising edge of the selected stage, so it first sets after half a period and then once per period.
- R5: A write to address 0 stores bit 5 (overflow interrupt enable), bit 4 (periodic interrupt enable) and bits 1:0 (rate). Written values at bit 7 and bit 6 are ignored.
- R6: Writing 1 to bit 3 clears the overflow flag, and writing 1 to bit 2 clears the periodic flag. Writing 0 to either bit leaves the flags unchanged. Bits 3 and 2 always read 0.
- R7: When a flag-set event and its clear strobe fall in the same cycle, the flag ends up set.
- R8: `irq_o` is high exactly when (bit 7 and bit 5) or (bit 6 and bit 4) are set.
- R9: `wd_tick_o` is a one-cycle pulse on every eighth periodic event. It appears in the same cycle that the periodic flag sets, so with rate 00 the first pulse comes after 15360 enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_en_i | input | 1 | Bus-rate enable that advances the divider chain |
| addr_i | input | 1 | Register select: 0 control/status, 1 counter |
| wr_en_i | input | 1 | Write strobe for the selected register |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the selected register (combinational) |
| irq_o | output | 1 | Combined interrupt request |
| wd_tick_o | output | 1 | Watchdog clock tick, one cycle wide |

## Verification
The hardest case to reach from the ports is a clear strobe that lands in exactly the cycle in which the overflow wraps. The bench keeps its own enable count and holds `tick_en_i` low while it sets up registers, so the enable count does not drift. It then advances the chain to one enable before the wrap and issues the clear write in the same cycle as the wrapping enable. A similar problem arises for the slow periodic rates and the watchdog tick, which need thousands of enables. The bench measures these by counting enables until the flag or the tick appears, then compares the count against the period derived from the rate.

// File: rtl/ctb_pkg.sv
`timescale 1ns/1ps
package ctb_pkg;
  localparam int DATA_W   = 8;
  localparam int SEL_W    = 2;
  localparam int NUM_TAPS = 1 << SEL_W;

  // control/status bit positions
  localparam int B_OVF_FLAG = 7;
  localparam int B_PER_FLAG = 6;
  localparam int B_OVF_IE   = 5;
  localparam int B_PER_IE   = 4;
  localparam int B_OVF_CLR  = 3;
  localparam int B_PER_CLR  = 2;

  typedef enum logic {
    ADDR_CSR = 1'b0,
    ADDR_CNT = 1'b1
  } addr_e;
endpackage

// File: rtl/ctb_chain.sv
`timescale 1ns/1ps
module ctb_chain #(
  parameter int W = 14
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  output logic [W-1:0] chain_o
);
  logic [W-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   chain_q <= '0;
    else if (en_i) chain_q <= chain_q + 1'b1;
  end

  assign chain_o = chain_q;

  p_chain_adv_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> chain_q == $past(chain_q) + 1'b1);
  p_chain_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(chain_q));
endmodule

// File: rtl/ctb_flag.sv
`timescale 1ns/1ps
module ctb_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flag_q <= 1'b0;
    else if (set_i)   flag_q <= 1'b1;  // set has priority over clear
    else if (clr_i)   flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  p_set_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_q);
  p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !flag_q);
  p_flag_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_i) |=> $stable(flag_q));
endmodule

// File: rtl/ctb_rti.sv
`timescale 1ns/1ps
module ctb_rti import ctb_pkg::*; #(
  parameter int W        = 14,
  parameter int TAP_BASE = 10,
  parameter int WD_BITS  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [W-1:0]     chain_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             evt_o,
  output logic             wd_tick_o
);
  logic [NUM_TAPS-1:0] rise;
  logic [WD_BITS-1:0]  wd_cnt_q;
  logic                wd_tick_q;

  // a tap rises on the enable that carries into it
  for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
    assign rise[t] = en_i && !chain_i[TAP_BASE+t] && (&chain_i[TAP_BASE+t-1:0]);
  end

  assign evt_o = rise[sel_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wd_cnt_q  <= '0;
      wd_tick_q <= 1'b0;
    end else begin
      wd_tick_q <= evt_o && (&wd_cnt_q);
      if (evt_o) wd_cnt_q <= wd_cnt_q + 1'b1;
    end
  end

  assign wd_tick_o = wd_tick_q;

  p_taps_exclusive_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rise));
  p_wd_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_tick_q |=> !wd_tick_q);
endmodule

// File: rtl/core_timebase.sv
`timescale 1ns/1ps
module core_timebase import ctb_pkg::*; #(
  parameter int PRE_BITS = 2,
  parameter int WD_BITS  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_en_i,
  input  logic              addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              wd_tick_o
);
  localparam int TAP_BASE = PRE_BITS + DATA_W;
  localparam int CHAIN_W  = TAP_BASE + NUM_TAPS;

  logic [CHAIN_W-1:0] chain;
  logic               wr_csr;
  logic               ovf_evt, per_evt;
  logic               ovf_flag, per_flag;
  logic               ovf_ie_q, per_ie_q;
  logic [SEL_W-1:0]   rate_q;

  assign wr_csr  = wr_en_i && (addr_i == ADDR_CSR);
  assign ovf_evt = tick_en_i && (&chain[TAP_BASE-1:0]);

  ctb_chain #(.W(CHAIN_W)) i_chain (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (tick_en_i),
    .chain_o (chain)
  );

  ctb_rti #(.W(CHAIN_W), .TAP_BASE(TAP_BASE), .WD_BITS(WD_BITS)) i_rti (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (tick_en_i),
    .chain_i   (chain),
    .sel_i     (rate_q),
    .evt_o     (per_evt),
    .wd_tick_o (wd_tick_o)
  );

  ctb_flag i_ovf_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (ovf_evt),
    .clr_i  (wr_csr && wdata_i[B_OVF_CLR]),
    .flag_o (ovf_flag)
  );

  ctb_flag i_per_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (per_evt),
    .clr_i  (wr_csr && wdata_i[B_PER_CLR]),
    .flag_o (per_flag)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_ie_q <= 1'b0;
      per_ie_q <= 1'b0;
      rate_q   <= '1;
    end else if (wr_csr) begin
      ovf_ie_q <= wdata_i[B_OVF_IE];
      per_ie_q <= wdata_i[B_PER_IE];
      rate_q   <= wdata_i[SEL_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_CNT) begin
      rdata_o = chain[TAP_BASE-1:PRE_BITS];
    end else begin
      rdata_o[B_OVF_FLAG] = ovf_flag;
      rdata_o[B_PER_FLAG] = per_flag;
      rdata_o[B_OVF_IE]   = ovf_ie_q;
      rdata_o[B_PER_IE]   = per_ie_q;
      rdata_o[SEL_W-1:0]  = rate_q;
    end
  end

  assign irq_o = (ovf_flag && ovf_ie_q) || (per_flag && per_ie_q);

  p_rate_wr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_csr |=> rate_q == $past(wdata_i[SEL_W-1:0]));
  p_irq_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (ovf_flag || per_flag));
  p_wd_with_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_tick_o |-> per_flag);
endmodule

// File: tb/test_core_timebase.sv
`timescale 1ns/1ps
module test_core_timebase;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       addr = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq;
  logic       wd_tick;

  int n_chk = 0;
  int n_bad = 0;
  int en_cnt = 0;

  always #2 clk = ~clk;

  core_timebase i_core_timebase (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .tick_en_i (tick_en),
    .addr_i    (addr),
    .wr_en_i   (wr_en),
    .wdata_i   (wdata),
    .rdata_o   (rdata),
    .irq_o     (irq),
    .wd_tick_o (wd_tick)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  task automatic step(input bit en);
    tick_en = en;
    @(posedge clk);
    if (en) en_cnt++;
    @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic wr(input bit a, input logic [7:0] d, input bit en);
    addr = a; wdata = d; wr_en = 1'b1;
    step(en);
    wr_en = 1'b0; addr = 1'b0;
  endtask

  task automatic rd(input bit a, output logic [7:0] v);
    addr = a;
    #0.1;
    v = rdata;
    addr = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tick_en = 1'b0; wr_en = 1'b0; addr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    en_cnt = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R1 watchdog act=running exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v, c;
    int first, second, pulses, wd_at;
    do_reset();

    // R1 reset state
    rd(1'b0, v); chk("R1 csr", v, 8'h03);
    rd(1'b1, v); chk("R1 cnt", v, 8'h00);
    chk("R1 irq", irq, 0);
    chk("R1 wd", wd_tick, 0);

    // R2/R3 sweep with an irregular enable pattern
    for (int i = 0; i < 2600; i++) begin
      step(i % 3 != 2);
      rd(1'b1, v); chk("R2 cnt", v, (en_cnt >> 2) & 255);
      rd(1'b0, v);
      chk("R3 ovf", v[7], en_cnt >= 1024);
      chk("R4 per idle", v[6], 0);
      chk("R8 irq off", irq, 0);
    end

    // R2 counter write ignored
    rd(1'b1, c);
    wr(1'b1, 8'h55, 1'b0);
    rd(1'b1, v); chk("R2 cnt write", v, c);

    // R5 flag positions ignored, rate written
    wr(1'b0, 8'hC0, 1'b0);
    rd(1'b0, v); chk("R5 csr", v, 8'h80);
    wr(1'b0, 8'h23, 1'b0);
    rd(1'b0, v); chk("R5 csr ie", v, 8'hA3);
    chk("R8 irq ovf", irq, 1);

    // R6 clear strobe
    wr(1'b0, 8'h2B, 1'b0);
    rd(1'b0, v); chk("R6 clr", v, 8'h23);
    chk("R8 irq cleared", irq, 0);

    // R7 set and clear together
    while (en_cnt < 2047) step(1'b1);
    rd(1'b0, v); chk("R7 pre", v[7], 0);
    wr(1'b0, 8'h2B, 1'b1);
    rd(1'b0, v); chk("R7 set wins", v[7], 1);
    wr(1'b0, 8'h23, 1'b0);
    rd(1'b0, v); chk("R6 zero strobe", v[7], 1);
    wr(1'b0, 8'h2B, 1'b0);
    rd(1'b0, v); chk("R6 clr2", v[7], 0);

    // R4 periods per rate select
    for (int s = 0; s < 4; s++) begin
      do_reset();
      wr(1'b0, 8'h10 | s, 1'b0);
      v = 0;
      while (!v[6] && en_cnt < 40000) begin step(1'b1); rd(1'b0, v); end
      first = en_cnt;
      chk("R4 first", first, 1024 << s);
      chk("R8 irq per", irq, 1);
      wr(1'b0, 8'h14 | s, 1'b0);
      rd(1'b0, v); chk("R6 per clr", v[6], 0);
      chk("R6 bits3:2", v[3:2], 0);
      while (!v[6] && en_cnt < 60000) begin step(1'b1); rd(1'b0, v); end
      second = en_cnt;
      chk("R4 period", second - first, 2048 << s);
    end

    // R9 watchdog tick
    do_reset();
    wr(1'b0, 8'h00, 1'b0);
    pulses = 0; wd_at = -1;
    for (int i = 0; i < 16000; i++) begin
      step(1'b1);
      if (wd_tick) begin
        pulses++;
        if (wd_at < 0) wd_at = en_cnt;
        rd(1'b0, v); chk("R9 flag with tick", v[6], 1);
      end
    end
    chk("R9 pulses", pulses, 1);
    chk("R9 first tick", wd_at, 15360);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule